// File: doc/BRIEF.md
# Fairness-Aware DRAM Request Arbiter

This block chooses one request per controller cycle from a small buffer of pending DRAM requests shared by several hardware threads. Each buffer slot presents a valid bit, the issuing thread, a target bank, a target row and an age, where a larger age means an older request. Alongside the slots the arbiter sees the row currently open in each bank, a fixed-point slowdown figure for every thread, a per-thread weight and a software-set unfairness limit.

Each cycle the arbiter scales each thread's slowdown by its weight. It compares the largest and smallest of these values over the threads that have at least one pending request. If the ratio stays under the limit, the order favours throughput: row hits first, then the oldest request. If the ratio reaches or passes the limit, the requests of the most-slowed thread come before everything else, and row hits and age only break ties inside that group and among the rest. The chosen slot index and a grant flag appear on registered outputs one cycle after the inputs they depend on. Command timing, refresh and the production of the slowdown numbers sit outside this block.

Top module: `fair_dram_arbiter`

## Requirements
- R1: A slot is a row hit exactly when its row field equals the open-row entry selected by its own bank field (bank b uses bits b*ROW_W upward of the open-row vector). A match against any other bank's open row does not count.
- R2: Outputs are registered. Inputs present before a rising edge decide the grant seen after that edge. While reset is high, grant_valid is 0 and grant_idx is 0.
- R3: If no slot is valid, grant_valid is 0 and grant_idx is 0 after the edge. If any slot is valid, grant_valid is 1 and grant_idx names a valid slot.
- R4: In throughput order, a valid row-hit slot wins over any row-miss slot. Among slots of equal hit status, the larger age wins.
- R5: Slots that are still equal after every criterion are resolved in favour of the lowest slot index.
- R6: Only threads with at least one valid slot take part in the largest/smallest weighted-slowdown evaluation. The slowdown and weight of any other thread have no effect on the grant.
- R7: The weighted slowdown of a thread is its slowdown times its weight. Fairness order applies when 16 × max_weighted ≥ threshold × min_weighted, where the threshold is unsigned with 4 fractional bits. Equality selects fairness order.
- R8: In fairness order, valid slots of the thread with the largest weighted slowdown come first, followed by row hits, then age. If several threads share the largest value, the lowest thread ID is the favoured one.
- R9: With the threshold at its all-ones value and a minimum weighted slowdown large enough that the test in R7 fails, the throughput order of R4 applies even when the slowdowns differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_ENTRIES | Per-slot valid bits |
| req_thread | input | N_ENTRIES*TID_W | Thread ID of each slot, slot e at bits e*TID_W |
| req_bank | input | N_ENTRIES*BANK_W | Bank of each slot |
| req_row | input | N_ENTRIES*ROW_W | Row of each slot |
| req_age | input | N_ENTRIES*AGE_W | Age of each slot, larger is older |
| open_row | input | N_BANKS*ROW_W | Currently open row of each bank |
| thread_slowdown | input | N_THREADS*SLOW_W | Fixed-point slowdown per thread |
| thread_weight | input | N_THREADS*WGT_W | Weight per thread |
| unfair_limit | input | THR_W | Unfairness threshold, 4 fractional bits |
| grant_valid | output | 1 | A slot was granted |
| grant_idx | output | IDX_W | Index of the granted slot |

## Verification
The bench builds the arbiter with its defaults: 8 threads, 16 slots, 8 banks, 12-bit slowdowns, 4-bit weights and a 12-bit threshold. This size makes it possible to set up thread-ID ties at the maximum, idle threads with huge slowdowns, and exact equality at the threshold with small integer values. A behavioural model recomputes the grant from the same stimulus every cycle. Directed cases cover the cross-bank hit rule, the ratio boundary and weight-driven changes of the favoured thread, and a long randomised run mixes both orders.

// File: rtl/fda_pkg.sv
package fda_pkg;
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fda_row_hit.sv
module fda_row_hit import fda_pkg::*; #(
  parameter int N_ENTRIES = 16,
  parameter int N_BANKS   = 8,
  parameter int ROW_W     = 14,
  localparam int BANK_W   = idx_w(N_BANKS)
) (
  input  logic [N_ENTRIES*BANK_W-1:0] req_bank,
  input  logic [N_ENTRIES*ROW_W-1:0]  req_row,
  input  logic [N_BANKS*ROW_W-1:0]    open_row,
  output logic [N_ENTRIES-1:0]        hit
);
  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_slot
    logic [BANK_W-1:0] bank;
    assign bank   = req_bank[e*BANK_W +: BANK_W];
    assign hit[e] = (req_row[e*ROW_W +: ROW_W] == open_row[bank*ROW_W +: ROW_W]);
  end
endmodule

// File: rtl/fda_fair_eval.sv
module fda_fair_eval import fda_pkg::*; #(
  parameter int N_THREADS = 8,
  parameter int N_ENTRIES = 16,
  parameter int SLOW_W    = 12,
  parameter int WGT_W     = 4,
  parameter int THR_W     = 12,
  parameter int FRAC_W    = 4,
  localparam int TID_W    = idx_w(N_THREADS),
  localparam int WS_W     = SLOW_W + WGT_W,
  localparam int CMP_W    = WS_W + THR_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_ENTRIES-1:0]          req_valid,
  input  logic [N_ENTRIES*TID_W-1:0]    req_thread,
  input  logic [N_THREADS*SLOW_W-1:0]   thread_slowdown,
  input  logic [N_THREADS*WGT_W-1:0]    thread_weight,
  input  logic [THR_W-1:0]              unfair_limit,
  output logic                          fair_mode,
  output logic [N_ENTRIES-1:0]          favored
);
  logic [N_THREADS-1:0] active;
  logic [WS_W-1:0]      wslow [N_THREADS];
  logic [WS_W-1:0]      max_w, min_w;
  logic [TID_W-1:0]     max_tid;
  logic                 seen;
  logic [CMP_W-1:0]     lhs, rhs;

  always_comb begin
    active = '0;
    for (int e = 0; e < N_ENTRIES; e++)
      if (req_valid[e]) active[req_thread[e*TID_W +: TID_W]] = 1'b1;
  end

  for (genvar t = 0; t < N_THREADS; t++) begin : g_weight
    assign wslow[t] = WS_W'(thread_slowdown[t*SLOW_W +: SLOW_W]) *
                      WS_W'(thread_weight[t*WGT_W +: WGT_W]);
  end

  always_comb begin
    seen    = 1'b0;
    max_w   = '0;
    min_w   = '0;
    max_tid = '0;
    for (int t = 0; t < N_THREADS; t++) begin
      if (active[t]) begin
        if (!seen || wslow[t] > max_w) begin
          max_w   = wslow[t];
          max_tid = TID_W'(t);
        end
        if (!seen || wslow[t] < min_w) min_w = wslow[t];
        seen = 1'b1;
      end
    end
  end

  assign lhs       = CMP_W'(max_w) << FRAC_W;
  assign rhs       = CMP_W'(unfair_limit) * CMP_W'(min_w);
  assign fair_mode = seen && (lhs >= rhs);

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_fav
    assign favored[e] = fair_mode && req_valid[e] &&
                        (req_thread[e*TID_W +: TID_W] == max_tid);
  end

  AST_FAIR_HAS_FAVORED: assert property (@(posedge clk) disable iff (rst)
    fair_mode |-> (|favored)); // R8
endmodule

// File: rtl/fda_select.sv
module fda_select import fda_pkg::*; #(
  parameter int N_ENTRIES = 16,
  parameter int AGE_W     = 8,
  localparam int IDX_W    = idx_w(N_ENTRIES),
  localparam int KEY_W    = AGE_W + 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_ENTRIES-1:0]       valid,
  input  logic [N_ENTRIES-1:0]       favored,
  input  logic [N_ENTRIES-1:0]       hit,
  input  logic [N_ENTRIES*AGE_W-1:0] age,
  output logic                       found,
  output logic [IDX_W-1:0]           idx
);
  logic [KEY_W-1:0] best, key;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    key   = '0;
    for (int e = 0; e < N_ENTRIES; e++) begin
      key = {favored[e], hit[e], age[e*AGE_W +: AGE_W]};
      if (valid[e] && (!found || key > best)) begin
        found = 1'b1;
        best  = key;
        idx   = IDX_W'(e);
      end
    end
  end

  AST_PICK_IS_VALID: assert property (@(posedge clk) disable iff (rst)
    found |-> valid[idx]); // R3
  AST_FAVORED_FIRST: assert property (@(posedge clk) disable iff (rst)
    (found && (|favored)) |-> favored[idx]); // R8
  AST_HIT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (found && !(|favored) && (|(valid & hit))) |-> hit[idx]); // R4
endmodule

// File: rtl/fair_dram_arbiter.sv
module fair_dram_arbiter import fda_pkg::*; #(
  parameter int N_THREADS = 8,
  parameter int N_ENTRIES = 16,
  parameter int N_BANKS   = 8,
  parameter int ROW_W     = 14,
  parameter int AGE_W     = 8,
  parameter int SLOW_W    = 12,
  parameter int WGT_W     = 4,
  parameter int THR_W     = 12,
  localparam int TID_W    = idx_w(N_THREADS),
  localparam int BANK_W   = idx_w(N_BANKS),
  localparam int IDX_W    = idx_w(N_ENTRIES)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_ENTRIES-1:0]         req_valid,
  input  logic [N_ENTRIES*TID_W-1:0]   req_thread,
  input  logic [N_ENTRIES*BANK_W-1:0]  req_bank,
  input  logic [N_ENTRIES*ROW_W-1:0]   req_row,
  input  logic [N_ENTRIES*AGE_W-1:0]   req_age,
  input  logic [N_BANKS*ROW_W-1:0]     open_row,
  input  logic [N_THREADS*SLOW_W-1:0]  thread_slowdown,
  input  logic [N_THREADS*WGT_W-1:0]   thread_weight,
  input  logic [THR_W-1:0]             unfair_limit,
  output logic                         grant_valid,
  output logic [IDX_W-1:0]             grant_idx
);
  logic [N_ENTRIES-1:0] hit, favored;
  logic                 fair_mode, found;
  logic [IDX_W-1:0]     pick;

  fda_row_hit #(.N_ENTRIES(N_ENTRIES), .N_BANKS(N_BANKS), .ROW_W(ROW_W)) u_hit (
    .req_bank(req_bank), .req_row(req_row), .open_row(open_row), .hit(hit));

  fda_fair_eval #(.N_THREADS(N_THREADS), .N_ENTRIES(N_ENTRIES), .SLOW_W(SLOW_W),
                  .WGT_W(WGT_W), .THR_W(THR_W), .FRAC_W(4)) u_eval (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_thread(req_thread),
    .thread_slowdown(thread_slowdown), .thread_weight(thread_weight),
    .unfair_limit(unfair_limit), .fair_mode(fair_mode), .favored(favored));

  fda_select #(.N_ENTRIES(N_ENTRIES), .AGE_W(AGE_W)) u_sel (
    .clk(clk), .rst(rst), .valid(req_valid), .favored(favored), .hit(hit),
    .age(req_age), .found(found), .idx(pick));

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_idx   <= '0;
    end else begin
      grant_valid <= found;
      grant_idx   <= pick;
    end
  end

  AST_GRANT_WHEN_PENDING: assert property (@(posedge clk) disable iff (rst)
    (|req_valid) |=> grant_valid); // R3
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    !(|req_valid) |=> (!grant_valid && grant_idx == '0)); // R3
endmodule

// File: tb/fair_dram_arbiter_tb.sv
`timescale 1ns/1ps
module fair_dram_arbiter_tb;
  localparam int NT = 8, NE = 16, NB = 8, RW = 14, AW = 8, SW = 12, WW = 4, TW = 12;
  localparam int TIDW = 3, BKW = 3, IXW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [NE-1:0]      req_valid = '0;
  logic [NE*TIDW-1:0] req_thread = '0;
  logic [NE*BKW-1:0]  req_bank = '0;
  logic [NE*RW-1:0]   req_row = '0;
  logic [NE*AW-1:0]   req_age = '0;
  logic [NB*RW-1:0]   open_row = '0;
  logic [NT*SW-1:0]   thread_slowdown = '0;
  logic [NT*WW-1:0]   thread_weight = '0;
  logic [TW-1:0]      unfair_limit = '0;
  logic               grant_valid;
  logic [IXW-1:0]     grant_idx;

  int b_v[NE], b_t[NE], b_b[NE], b_r[NE], b_a[NE];
  int b_open[NB], b_slow[NT], b_wgt[NT];
  int b_lim;
  int checks = 0, fails = 0;
  bit exp_v;
  int exp_i;

  always #2 clk = ~clk;

  fair_dram_arbiter u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_thread(req_thread),
    .req_bank(req_bank), .req_row(req_row), .req_age(req_age), .open_row(open_row),
    .thread_slowdown(thread_slowdown), .thread_weight(thread_weight),
    .unfair_limit(unfair_limit), .grant_valid(grant_valid), .grant_idx(grant_idx));

  task automatic pack_inputs();
    for (int e = 0; e < NE; e++) begin
      req_valid[e]              = b_v[e][0];
      req_thread[e*TIDW +: TIDW] = TIDW'(b_t[e]);
      req_bank[e*BKW +: BKW]     = BKW'(b_b[e]);
      req_row[e*RW +: RW]        = RW'(b_r[e]);
      req_age[e*AW +: AW]        = AW'(b_a[e]);
    end
    for (int b = 0; b < NB; b++) open_row[b*RW +: RW] = RW'(b_open[b]);
    for (int t = 0; t < NT; t++) begin
      thread_slowdown[t*SW +: SW] = SW'(b_slow[t]);
      thread_weight[t*WW +: WW]   = WW'(b_wgt[t]);
    end
    unfair_limit = TW'(b_lim);
  endtask

  task automatic model();
    bit act[NT];
    bit seen = 0, fair;
    longint mx = 0, mn = 0, ws, best = 0, score;
    int mt = 0;
    for (int t = 0; t < NT; t++) act[t] = 0;
    for (int e = 0; e < NE; e++) if (b_v[e] != 0) act[b_t[e]] = 1;
    for (int t = 0; t < NT; t++) begin
      ws = longint'(b_slow[t]) * b_wgt[t];
      if (act[t]) begin
        if (!seen || ws > mx) begin mx = ws; mt = t; end
        if (!seen || ws < mn) mn = ws;
        seen = 1;
      end
    end
    fair = seen && (mx * 16 >= longint'(b_lim) * mn);
    exp_v = 0; exp_i = 0;
    for (int e = 0; e < NE; e++) begin
      if (b_v[e] != 0) begin
        score = b_a[e];
        if (b_r[e] == b_open[b_b[e]]) score += 1000;
        if (fair && b_t[e] == mt) score += 100000;
        if (!exp_v || score > best) begin exp_v = 1; exp_i = e; best = score; end
      end
    end
  endtask

  task automatic check(input string tag);
    checks++;
    if (grant_valid !== exp_v || int'(grant_idx) !== exp_i) begin
      fails++;
      $display("FAIL %s: grant_valid=%0b grant_idx=%0d expected valid=%0b idx=%0d",
               tag, grant_valid, grant_idx, exp_v, exp_i);
    end
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    pack_inputs();
    model();
    @(posedge clk);
    #1;
    check(tag);
  endtask

  task automatic clear_all();
    for (int e = 0; e < NE; e++) begin
      b_v[e] = 0; b_t[e] = 0; b_b[e] = 0; b_r[e] = 7; b_a[e] = 0;
    end
    for (int b = 0; b < NB; b++) b_open[b] = 100 + b;
    for (int t = 0; t < NT; t++) begin b_slow[t] = 16; b_wgt[t] = 1; end
    b_lim = 24;
  endtask

  task automatic slot(input int e, input int th, input int bk, input bit is_hit, input int ag);
    b_v[e] = 1; b_t[e] = th; b_b[e] = bk; b_a[e] = ag;
    b_r[e] = is_hit ? 100 + bk : 7;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    clear_all();
    pack_inputs();
    repeat (3) @(posedge clk);
    #1;
    exp_v = 0; exp_i = 0;
    check("R2 reset state");
    @(negedge clk);
    rst = 1'b0;

    clear_all();
    step("R3 empty buffer");

    // R1: slot 4 carries the open row of bank 3 but targets bank 2
    clear_all(); slot(4, 0, 2, 0, 10); b_r[4] = 103; slot(6, 1, 3, 0, 20);
    step("R1 cross-bank row is a miss");
    clear_all(); slot(4, 0, 2, 0, 10); b_r[4] = 102; slot(6, 1, 3, 0, 20);
    step("R1 own-bank row is a hit");

    clear_all(); slot(3, 0, 1, 0, 200); slot(5, 1, 4, 1, 2);
    step("R4 hit beats older miss");
    clear_all(); slot(3, 0, 1, 0, 30); slot(5, 1, 4, 0, 90);
    step("R4 older wins among misses");

    clear_all(); slot(9, 0, 1, 1, 40); slot(2, 1, 2, 1, 40); slot(12, 2, 3, 1, 40);
    step("R5 full tie lowest index");

    // R7/R8: thread 2 at 40 vs thread 0 at 16, limit 1.5
    clear_all(); slot(0, 0, 0, 1, 50); slot(1, 2, 1, 0, 1); b_slow[2] = 40;
    step("R8 favoured miss beats hit");
    b_slow[2] = 20;
    step("R7 ratio below limit");
    b_slow[2] = 24;
    step("R7 ratio equal to limit");
    b_slow[2] = 23;
    step("R7 ratio just below limit");

    clear_all(); slot(0, 0, 0, 1, 50); slot(1, 2, 1, 0, 1);
    b_slow[2] = 10; b_wgt[2] = 4;
    step("R7 weight raises thread");
    b_slow[0] = 40; b_wgt[2] = 1;
    step("R7 weight lowered swaps favourite");

    clear_all(); slot(0, 0, 0, 1, 50); b_slow[7] = 4000; b_wgt[7] = 15;
    slot(1, 2, 1, 0, 60);
    step("R6 idle thread ignored");

    clear_all(); slot(0, 0, 0, 1, 90); slot(1, 5, 1, 1, 9); slot(2, 2, 2, 0, 1);
    b_slow[2] = 40; b_slow[5] = 40;
    step("R8 tie at max lowest thread");
    clear_all(); slot(1, 2, 1, 0, 100); slot(3, 2, 2, 1, 0); slot(4, 0, 3, 1, 200);
    b_slow[2] = 40;
    step("R8 hit first inside favoured");

    clear_all(); b_lim = 4095; slot(0, 0, 0, 1, 5); slot(1, 2, 1, 0, 99);
    b_slow[0] = 300; b_slow[2] = 4000;
    step("R9 huge limit keeps throughput");

    clear_all();
    step("R3 empty again");

    for (int n = 0; n < 3000; n++) begin
      clear_all();
      b_lim = 16 + int'($urandom_range(0, 48));
      for (int t = 0; t < NT; t++) begin
        b_slow[t] = int'($urandom_range(1, 80));
        b_wgt[t]  = int'($urandom_range(0, 3));
      end
      for (int e = 0; e < NE; e++)
        if ($urandom_range(0, 2) == 0)
          slot(e, int'($urandom_range(0, NT-1)), int'($urandom_range(0, NB-1)),
               $urandom_range(0, 1) == 1, int'($urandom_range(0, 7)));
      step("R8 random mix");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule